// File: doc/BRIEF.md
# Sleep and Start-up Gate for a Serial Slave Bus

This block sits between the SCL/SDA input buffers and a two-wire slave engine, and decides when that engine may see bus traffic. It watches an active-low reset, a power-down pin, a digital supply-good level and a request for a security penalty. The bus lines reach the slave only after the chip has settled, and never while it sleeps.

Two guard intervals are measured by counting pulses of a slow tick input, nominally 1 kHz. The start-up interval begins at whichever comes later: supply-good rising or reset being released. While a security penalty is requested, the start-up interval is longer by a programmable count. Leaving power-down after a completed start-up uses a shorter wake interval. If reset or a supply loss cuts a count short, that count begins again from zero. While the lines are closed, the slave sees both lines held high, which is an idle bus, so it cannot detect a false start condition.

Top module: `bus_wake_gate`

## Requirements
- R1: When rst_ni goes low, the block returns to its start-up state at once, even while pdn_i is high: ready_o is low and scl_o and sda_o are high. After reset is released, the full start-up interval must run again, even if a wake interval would otherwise apply.
- R2: With supply_ok_i high, rst_ni high, pdn_i low and sec_delay_i low, ready_o rises in the clock cycle after the BOOT_TICKS-th tick_i pulse. Counting starts at the later of supply-good rising or reset release, and no tick_i pulse counts while supply_ok_i is low.
- R3: While sec_delay_i is high during start-up, ready_o rises only after BOOT_TICKS + PENALTY_TICKS tick_i pulses.
- R4: While pdn_i is high, sleep_o is high and ready_o is low in the same cycle, and tick_i pulses have no effect.
- R5: When pdn_i falls after a start-up has completed, ready_o rises in the cycle after the WAKE_TICKS-th tick_i pulse.
- R6: When pdn_i falls and no start-up has completed since the last reset or supply loss, the full start-up interval applies instead of the wake interval.
- R7: If supply_ok_i drops while a count is running, the count restarts from zero once supply_ok_i returns.
- R8: When ready_o is low, scl_o and sda_o are both 1 whatever scl_i and sda_i do. When ready_o is high, scl_o equals scl_i and sda_o equals sda_i.
- R9: When supply_ok_i is low at a clock edge, ready_o is low from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Supply-good level from the monitor |
| pdn_i | input | 1 | Power-down request, high = sleep |
| sec_delay_i | input | 1 | Security penalty request |
| tick_i | input | 1 | Prescaled time-base pulse, one clock wide |
| scl_i | input | 1 | Clock line from the pad |
| sda_i | input | 1 | Data line from the pad |
| scl_o | output | 1 | Gated clock line toward the slave |
| sda_o | output | 1 | Gated data line toward the slave |
| ready_o | output | 1 | High when bus traffic is accepted |
| sleep_o | output | 1 | High while in power-down |

## Verification
The bench builds the block with BOOT_TICKS=6, WAKE_TICKS=4 and PENALTY_TICKS=10, in place of 60, 50 and 1000. With these short intervals, every boundary can be reached in a few hundred cycles: the last tick before the edge and the tick that completes each interval, for start-up, wake and penalty alike. The small values also leave room for the restart cases, where a supply loss cuts a start-up count short, a power-down interrupts a start-up, and a reset arrives while the block sleeps. The distinct values make it visible which interval was applied, because a wake interval of 4 ends earlier than a start-up interval of 6.

// File: rtl/bwg_pkg.sv
package bwg_pkg;
  typedef enum logic [1:0] {
    ST_BOOT  = 2'd0,
    ST_SLEEP = 2'd1,
    ST_WAKE  = 2'd2,
    ST_READY = 2'd3
  } bwg_state_e;
endpackage

// File: rtl/bwg_tick_timer.sv
module bwg_tick_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  // done on the tick that completes the interval
  assign done_o = tick_i && !clr_i && (cnt_q >= limit_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i || done_o) begin
      cnt_q <= '0;
    end else if (tick_i && (cnt_q != '1)) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/bwg_line_gate.sv
module bwg_line_gate #(
  parameter int unsigned LINES = 2
) (
  input  logic             open_i,
  input  logic [LINES-1:0] line_i,
  output logic [LINES-1:0] line_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    // closed line reads as released (idle high)
    assign line_o[g] = open_i ? line_i[g] : 1'b1;
  end
endmodule

// File: rtl/bus_wake_gate.sv
module bus_wake_gate #(
  parameter int unsigned BOOT_TICKS    = 60,
  parameter int unsigned WAKE_TICKS    = 50,
  parameter int unsigned PENALTY_TICKS = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic pdn_i,
  input  logic sec_delay_i,
  input  logic tick_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic ready_o,
  output logic sleep_o
);
  import bwg_pkg::*;

  localparam int unsigned MaxTicks = BOOT_TICKS + PENALTY_TICKS;
  localparam int unsigned CntW     = $clog2(MaxTicks + 1);
  localparam logic [CntW-1:0] BootLim = CntW'(BOOT_TICKS);
  localparam logic [CntW-1:0] PenLim  = CntW'(MaxTicks);
  localparam logic [CntW-1:0] WakeLim = CntW'(WAKE_TICKS);

  bwg_state_e      state_q;
  logic            boot_done_q;
  logic            tmr_clr;
  logic            tmr_done;
  logic [CntW-1:0] tmr_limit;
  logic            gate_open;
  logic [1:0]      pad_lines;
  logic [1:0]      slv_lines;

  always_comb begin
    if (state_q == ST_WAKE)  tmr_limit = WakeLim;
    else if (sec_delay_i)    tmr_limit = PenLim;
    else                     tmr_limit = BootLim;
  end

  assign tmr_clr = !supply_ok_i || pdn_i ||
                   (state_q == ST_SLEEP) || (state_q == ST_READY);

  bwg_tick_timer #(.CNT_W(CntW)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (tmr_clr),
    .tick_i  (tick_i),
    .limit_i (tmr_limit),
    .done_o  (tmr_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_BOOT;
      boot_done_q <= 1'b0;
    end else if (!supply_ok_i) begin
      state_q     <= ST_BOOT;
      boot_done_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_SLEEP: begin
          if (!pdn_i) state_q <= boot_done_q ? ST_WAKE : ST_BOOT;
        end
        ST_READY: begin
          if (pdn_i) state_q <= ST_SLEEP;
        end
        default: begin
          if (pdn_i) begin
            state_q <= ST_SLEEP;
          end else if (tmr_done) begin
            state_q <= ST_READY;
            if (state_q == ST_BOOT) boot_done_q <= 1'b1;
          end
        end
      endcase
    end
  end

  assign gate_open = (state_q == ST_READY) && !pdn_i;
  assign ready_o   = gate_open;
  assign sleep_o   = pdn_i || (state_q == ST_SLEEP);

  assign pad_lines = {scl_i, sda_i};

  bwg_line_gate #(.LINES(2)) i_gate (
    .open_i (gate_open),
    .line_i (pad_lines),
    .line_o (slv_lines)
  );

  assign scl_o = slv_lines[1];
  assign sda_o = slv_lines[0];
endmodule

// File: rtl/bus_wake_gate_chk.sv
module bus_wake_gate_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic supply_ok_i,
  input logic pdn_i,
  input logic tick_i,
  input logic scl_i,
  input logic sda_i,
  input logic scl_o,
  input logic sda_o,
  input logic ready_o,
  input logic sleep_o
);
  p_sleep_blocks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdn_i |-> (sleep_o && !ready_o));

  p_gate_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (scl_o && sda_o));

  p_gate_pass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> ((scl_o == scl_i) && (sda_o == sda_i)));

  p_supply_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> !ready_o);

  // R2: readiness only ever follows a counted tick
  p_ready_after_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ready_o) && !$past(pdn_i)) |-> $past(tick_i));

  // R1: reset state
  always_comb begin
    if (!rst_ni) begin
      p_reset_idle_r1: assert (!ready_o && scl_o && sda_o);
    end
  end
endmodule

bind bus_wake_gate bus_wake_gate_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .supply_ok_i (supply_ok_i),
  .pdn_i       (pdn_i),
  .tick_i      (tick_i),
  .scl_i       (scl_i),
  .sda_i       (sda_i),
  .scl_o       (scl_o),
  .sda_o       (sda_o),
  .ready_o     (ready_o),
  .sleep_o     (sleep_o)
);

// File: tb/test_bus_wake_gate.sv
`timescale 1ns/1ps
module test_bus_wake_gate;
  localparam int unsigned BOOT = 6;
  localparam int unsigned WAKE = 4;
  localparam int unsigned PEN  = 10;
  localparam int NVEC = 21;

  // {supply, pdn, sec, ticks[7:0], exp_ready, exp_sleep}
  localparam logic [12:0] VEC [NVEC] = '{
    13'b0_0_0_00001010_0_0, // 0  R2 ticks ignored without supply
    13'b1_0_0_00000101_0_0, // 1  R2 one short
    13'b1_0_0_00000001_1_0, // 2  R2 boot complete
    13'b1_1_0_00000000_0_1, // 3  R4 sleep
    13'b1_1_0_00010100_0_1, // 4  R4 ticks in sleep
    13'b1_0_0_00000011_0_0, // 5  R5 one short of wake
    13'b1_0_0_00000001_1_0, // 6  R5 wake complete
    13'b0_0_0_00000000_0_0, // 7  R9 supply drop
    13'b1_0_1_00001111_0_0, // 8  R3 one short of penalty
    13'b1_0_1_00000001_1_0, // 9  R3 penalty complete
    13'b1_0_0_00000011_1_0, // 10 R3 stays ready
    13'b0_0_0_00000000_0_0, // 11 R9
    13'b1_0_0_00000100_0_0, // 12 R7 partial count
    13'b0_0_0_00000010_0_0, // 13 R7 interrupted
    13'b1_0_0_00000101_0_0, // 14 R7 restarted, one short
    13'b1_0_0_00000001_1_0, // 15 R7 complete
    13'b0_0_0_00000000_0_0, // 16 R9
    13'b1_0_0_00000011_0_0, // 17 R6 partial boot
    13'b1_1_0_00000010_0_1, // 18 R6 sleep during boot
    13'b1_0_0_00000101_0_0, // 19 R6 wake interval not used
    13'b1_0_0_00000001_1_0  // 20 R6 full boot done
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0, pdn = 1'b0, sec = 1'b0, tick = 1'b0;
  logic scl_i = 1'b0, sda_i = 1'b0;
  logic scl_o, sda_o, ready, sleep;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bus_wake_gate #(.BOOT_TICKS(BOOT), .WAKE_TICKS(WAKE), .PENALTY_TICKS(PEN)) i_bus_wake_gate (
    .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(supply_ok), .pdn_i(pdn),
    .sec_delay_i(sec), .tick_i(tick), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_o), .sda_o(sda_o), .ready_o(ready), .sleep_o(sleep)
  );

  function automatic string row_tag(int i);
    case (i)
      0, 1, 2:            return "R2";
      3, 4:               return "R4";
      5, 6:               return "R5";
      8, 9, 10:           return "R3";
      12, 13, 14, 15:     return "R7";
      17, 18, 19, 20:     return "R6";
      default:            return "R9";
    endcase
  endfunction

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic check(string tag, logic exp_rdy, logic exp_slp);
    logic exp_scl, exp_sda;
    exp_scl = exp_rdy ? scl_i : 1'b1;
    exp_sda = exp_rdy ? sda_i : 1'b1;
    n_chk++;
    if (ready !== exp_rdy || sleep !== exp_slp || scl_o !== exp_scl || sda_o !== exp_sda) begin
      n_fail++;
      $display("FAIL %s: rdy/slp/scl/sda act %b%b%b%b exp %b%b%b%b", tag,
               ready, sleep, scl_o, sda_o, exp_rdy, exp_slp, exp_scl, exp_sda);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", 1'b0, 1'b0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      supply_ok = VEC[i][12];
      pdn       = VEC[i][11];
      sec       = VEC[i][10];
      ticks(int'(VEC[i][9:2]));
      @(negedge clk);
      check(row_tag(i), VEC[i][1], VEC[i][0]);
    end

    // R8: lines pass when ready
    scl_i = 1'b1; sda_i = 1'b0; #1; check("R8 pass 10", 1'b1, 1'b0);
    scl_i = 1'b0; sda_i = 1'b1; #1; check("R8 pass 01", 1'b1, 1'b0);

    // R8/R4: toggles in sleep stay blocked
    @(negedge clk) pdn = 1'b1;
    @(negedge clk);
    scl_i = 1'b0; sda_i = 1'b0; #1; check("R8 blocked 00", 1'b0, 1'b1);
    scl_i = 1'b1; sda_i = 1'b0; #1; check("R8 blocked 10", 1'b0, 1'b1);

    // R1: reset while asleep, then full boot required
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    scl_i = 1'b0; #1;
    check("R1 reset in sleep", 1'b0, 1'b1);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk) pdn = 1'b0;
    ticks(WAKE);
    @(negedge clk);
    check("R1 wake interval not used", 1'b0, 1'b0);
    ticks(BOOT - WAKE);
    @(negedge clk);
    check("R1 full boot after reset", 1'b1, 1'b0);

    // R9: supply drop while ready, checked one edge later
    @(negedge clk) supply_ok = 1'b0;
    @(negedge clk);
    check("R9 drop while ready", 1'b0, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: act timeout exp completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule